// File: doc/BRIEF.md
# Exception Vector Base and Entry Address Generator

This block holds the per-CPU exception base register of a 32-bit processor core. It computes the fetch address that the front end jumps to when an exception is taken. Software reads and writes the register through a 32-bit strobe interface. The CPU number sits in its low bits as a read-only value tied in from a core strap. The upper address bits are pinned so that the base always lands in the unmapped kernel window. Giving each CPU of a shared-memory system its own base gives it its own handlers.

The entry address depends on several inputs:
- the exception kind;
- the boot-vector mode bit;
- a ROM base, which can be relocated by strap;
- a programmable debug vector with its enable;
- a probe-present flag.

Reset and NMI always enter at the ROM base. Debug entries choose a vector in this priority order:
1. the probe vector;
2. the programmable debug vector;
3. a fixed ROM offset.

All other kinds add a per-kind offset, either to the ROM area while boot mode is on or to the software base otherwise. Cache-error entries use the uncached alias of their address.

Top module: `evb_vector_unit`

## Requirements
- R1: After reset the register reads 0x8000_0000 ORed with the CPU-number strap in bits 9:0.
- R2: A write strobe loads bits 29:12 of the write data into the base field, and the new value is visible on the read port one cycle later. Bits 31:30 always read binary 10 and bits 11:10 always read 0. With the strobe low the register holds its value.
- R3: Bits 9:0 of the read value follow the CPU-number strap at all times, and write data never changes them.
- R4: The ROM base is 0xBFC0_0000 while the relocation strap is low. While the strap is high, the ROM base is binary 10 in bits 31:30, the 18-bit strap base in bits 29:12 and zero in bits 11:0.
- R5: Exception kinds are encoded as follows: 0 reset, 1 NMI, 2 TLB refill, 3 cache error, 4 general, 5 interrupt with dedicated vector, 6 debug. Kinds 0 and 1 produce the ROM base whatever the boot-mode bit is.
- R6: With the boot-mode bit at 1, kinds 2, 3, 4 and 5 produce the ROM base plus 0x200 plus a kind offset. The offsets are 0x000 for kind 2, 0x100 for kind 3, 0x180 for kind 4 and 0x200 for kind 5.
- R7: With the boot-mode bit at 0, the same kinds produce the register base (read value with bits 11:0 cleared) plus the same kind offsets. The relocation strap has no effect on them.
- R8: For kind 3, bit 29 of the vector is forced to 1.
- R9: For kind 6, with no probe and the debug vector disabled, the vector is the ROM base plus 0x480.
- R10: For kind 6 with the probe present, the vector is 0xFF20_0200 regardless of the debug enable. Without the probe but with the debug enable set, the vector is the programmable debug address.
- R11: A write is accepted whatever the boot-mode bit is. The vector output is combinational, so it reflects the new base in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value |
| cpu_num_strap | input | 10 | Tied-off CPU number |
| exc_kind | input | 3 | Exception kind code being taken |
| boot_vec_mode | input | 1 | Boot-vector mode bit from status |
| rom_reloc_en | input | 1 | ROM base relocation strap enable |
| rom_reloc_page | input | 18 | Relocated ROM base bits 29:12 |
| dbg_vec_en | input | 1 | Programmable debug vector enable |
| dbg_vec_addr | input | 32 | Programmable debug vector address |
| probe_present | input | 1 | Debug probe handles debug entries |
| vec_addr | output | 32 | Selected exception entry address |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 10-bit CPU number, 4 KB base granularity and a probe vector of 0xFF20_0200. With these values the register layout is the one software sees, so the bench can predict every expected address as a literal hex value. That makes it possible to cover every kind in both boot modes, with and without ROM relocation, and all three debug priority levels. It also lets the bench check that the uncached bit lands correctly on both a relocated base and a software-written base.

// File: rtl/evb_pkg.sv
package evb_pkg;

    localparam int XLEN     = 32;
    localparam int SEG_W    = 2;
    localparam int PAGE_LSB = 12;
    localparam int PAGE_W   = XLEN - SEG_W - PAGE_LSB;
    localparam int CPUID_W  = 10;

    localparam logic [SEG_W-1:0] KSEG_TAG = 2'b10;

    typedef enum logic [2:0] {
        EXC_RESET      = 3'd0,
        EXC_NMI        = 3'd1,
        EXC_TLB_REFILL = 3'd2,
        EXC_CACHE_ERR  = 3'd3,
        EXC_GENERAL    = 3'd4,
        EXC_INTR_VEC   = 3'd5,
        EXC_DEBUG      = 3'd6
    } exc_kind_e;

endpackage

// File: rtl/evb_base_reg.sv
module evb_base_reg #(
    parameter int XW = 32,
    parameter int PL = 12,
    parameter int CW = 10,
    parameter int SW = 2,
    parameter logic [SW-1:0] TAG = 2'b10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [XW-1:0] wr_data,
    input  logic [CW-1:0] cpu_num,
    output logic [XW-1:0] rd_data,
    output logic [XW-1:0] base_addr
);
    localparam int PW    = XW - SW - PL;
    localparam int GAP_W = PL - CW;

    typedef struct packed {
        logic [PW-1:0] page;
    } base_state_t;

    base_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.page = wr_data[XW-SW-1:PL];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[XW-1:XW-SW], wr_data[PL-1:0]};

    generate
        if (GAP_W > 0) begin : g_gap
            assign rd_data = {TAG, st_q.page, {GAP_W{1'b0}}, cpu_num};
        end else begin : g_nogap
            assign rd_data = {TAG, st_q.page, cpu_num[PL-1:0]};
        end
    endgenerate

    assign base_addr = {TAG, st_q.page, {PL{1'b0}}};

    // R2: a strobed write lands in the base field one cycle later
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[XW-SW-1:PL] == $past(wr_data[XW-SW-1:PL]));

    // R2: without a strobe the address part stays put
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> $stable(rd_data[XW-1:PL]));

endmodule

// File: rtl/evb_rom_base.sv
module evb_rom_base #(
    parameter int XW = 32,
    parameter int PL = 12,
    parameter int SW = 2,
    parameter logic [SW-1:0] TAG = 2'b10,
    parameter logic [XW-1:0] ROM_DEFAULT = 32'hBFC0_0000
) (
    input  logic                 reloc_en,
    input  logic [XW-SW-PL-1:0]  reloc_page,
    output logic [XW-1:0]        rom_base
);
    always_comb begin
        if (reloc_en) begin
            rom_base = {TAG, reloc_page, {PL{1'b0}}};
        end else begin
            rom_base = ROM_DEFAULT;
        end
    end
endmodule

// File: rtl/evb_vector_sel.sv
module evb_vector_sel
    import evb_pkg::*;
#(
    parameter int XW = 32,
    parameter int UNCACHED_BIT = 29,
    parameter logic [XW-1:0] PROBE_VEC = 32'hFF20_0200,
    parameter logic [XW-1:0] OFF_TLB   = 32'h000,
    parameter logic [XW-1:0] OFF_CERR  = 32'h100,
    parameter logic [XW-1:0] OFF_GEN   = 32'h180,
    parameter logic [XW-1:0] OFF_INTV  = 32'h200,
    parameter logic [XW-1:0] OFF_BOOT  = 32'h200,
    parameter logic [XW-1:0] OFF_DBG   = 32'h480
) (
    input  logic [2:0]    kind,
    input  logic          boot_mode,
    input  logic [XW-1:0] rom_base,
    input  logic [XW-1:0] exc_base,
    input  logic          dbg_en,
    input  logic [XW-1:0] dbg_addr,
    input  logic          probe,
    output logic [XW-1:0] vec
);
    exc_kind_e     k;
    logic [XW-1:0] kind_off;
    logic [XW-1:0] area_base;
    logic [XW-1:0] normal_vec;
    logic [XW-1:0] debug_vec;

    always_comb begin
        k = exc_kind_e'(kind);
        case (k)
            EXC_TLB_REFILL: kind_off = OFF_TLB;
            EXC_CACHE_ERR:  kind_off = OFF_CERR;
            EXC_INTR_VEC:   kind_off = OFF_INTV;
            default:        kind_off = OFF_GEN;
        endcase

        area_base  = boot_mode ? (rom_base + OFF_BOOT) : exc_base;
        normal_vec = area_base + kind_off;
        if (k == EXC_CACHE_ERR) begin
            normal_vec[UNCACHED_BIT] = 1'b1;
        end

        if (probe) begin
            debug_vec = PROBE_VEC;
        end else if (dbg_en) begin
            debug_vec = dbg_addr;
        end else begin
            debug_vec = rom_base + OFF_DBG;
        end

        case (k)
            EXC_RESET, EXC_NMI: vec = rom_base;
            EXC_DEBUG:          vec = debug_vec;
            default:            vec = normal_vec;
        endcase
    end
endmodule

// File: rtl/evb_vector_unit.sv
module evb_vector_unit
    import evb_pkg::*;
#(
    parameter int XW = XLEN,
    parameter int PL = PAGE_LSB,
    parameter int CW = CPUID_W,
    parameter int SW = SEG_W,
    parameter logic [XW-1:0] ROM_DEFAULT = 32'hBFC0_0000,
    parameter logic [XW-1:0] PROBE_VEC   = 32'hFF20_0200
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [XW-1:0]       wr_data,
    output logic [XW-1:0]       rd_data,
    input  logic [CW-1:0]       cpu_num_strap,
    input  logic [2:0]          exc_kind,
    input  logic                boot_vec_mode,
    input  logic                rom_reloc_en,
    input  logic [XW-SW-PL-1:0] rom_reloc_page,
    input  logic                dbg_vec_en,
    input  logic [XW-1:0]       dbg_vec_addr,
    input  logic                probe_present,
    output logic [XW-1:0]       vec_addr
);
    localparam int UNC_BIT = XW - SW - 1;

    logic [XW-1:0] exc_base;
    logic [XW-1:0] rom_base;

    evb_base_reg #(.XW(XW), .PL(PL), .CW(CW), .SW(SW), .TAG(KSEG_TAG)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cpu_num   (cpu_num_strap),
        .rd_data   (rd_data),
        .base_addr (exc_base)
    );

    evb_rom_base #(.XW(XW), .PL(PL), .SW(SW), .TAG(KSEG_TAG),
                   .ROM_DEFAULT(ROM_DEFAULT)) u_rom (
        .reloc_en   (rom_reloc_en),
        .reloc_page (rom_reloc_page),
        .rom_base   (rom_base)
    );

    evb_vector_sel #(.XW(XW), .UNCACHED_BIT(UNC_BIT), .PROBE_VEC(PROBE_VEC)) u_sel (
        .kind      (exc_kind),
        .boot_mode (boot_vec_mode),
        .rom_base  (rom_base),
        .exc_base  (exc_base),
        .dbg_en    (dbg_vec_en),
        .dbg_addr  (dbg_vec_addr),
        .probe     (probe_present),
        .vec       (vec_addr)
    );

    // R4: ROM base falls back to its default when the strap is off
    a_r4_rom_default: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_reloc_en |-> rom_base == ROM_DEFAULT);

    // R5: reset and NMI enter at the ROM base
    a_r5_rom_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_kind == EXC_RESET || exc_kind == EXC_NMI) |-> vec_addr == rom_base);

    // R7: general entry in normal mode tracks the register's address part
    a_r7_base_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_kind == EXC_GENERAL && !boot_vec_mode)
            |-> vec_addr[XW-1:PL] == rd_data[XW-1:PL]);

    // R8: cache-error entries use the uncached alias
    a_r8_uncached: assert property (@(posedge clk) disable iff (!rst_n)
        exc_kind == EXC_CACHE_ERR |-> vec_addr[UNC_BIT]);

    // R10: probe vector wins over everything for debug entries
    a_r10_probe_first: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_kind == EXC_DEBUG && probe_present) |-> vec_addr == PROBE_VEC);

endmodule

// File: tb/evb_vector_unit_bench.sv
module evb_vector_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [9:0]  cpu_num_strap = 10'h2A5;
    logic [2:0]  exc_kind = 3'd0;
    logic        boot_vec_mode = 1'b0;
    logic        rom_reloc_en = 1'b0;
    logic [17:0] rom_reloc_page = '0;
    logic        dbg_vec_en = 1'b0;
    logic [31:0] dbg_vec_addr = 32'h9000_1000;
    logic        probe_present = 1'b0;
    logic [31:0] vec_addr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    evb_vector_unit u_evb_vector_unit (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .rd_data        (rd_data),
        .cpu_num_strap  (cpu_num_strap),
        .exc_kind       (exc_kind),
        .boot_vec_mode  (boot_vec_mode),
        .rom_reloc_en   (rom_reloc_en),
        .rom_reloc_page (rom_reloc_page),
        .dbg_vec_en     (dbg_vec_en),
        .dbg_vec_addr   (dbg_vec_addr),
        .probe_present  (probe_present),
        .vec_addr       (vec_addr)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  kind;
        logic        bev;
        logic        reloc;
        logic [17:0] page;
        logic        den;
        logic        probe;
        logic [31:0] exp;
    } row_t;

    // kinds: 0 reset,1 NMI,2 TLB,3 cache err,4 general,5 intr,6 debug
    localparam int NROWS = 18;
    localparam row_t TBL [NROWS] = '{
        '{4'd5,  3'd0, 1'b0, 1'b0, 18'h0,    1'b0, 1'b0, 32'hBFC0_0000}, // R5
        '{4'd5,  3'd1, 1'b1, 1'b0, 18'h0,    1'b0, 1'b0, 32'hBFC0_0000}, // R5
        '{4'd6,  3'd4, 1'b1, 1'b0, 18'h0,    1'b0, 1'b0, 32'hBFC0_0380}, // R6
        '{4'd6,  3'd2, 1'b1, 1'b0, 18'h0,    1'b0, 1'b0, 32'hBFC0_0200}, // R6
        '{4'd6,  3'd3, 1'b1, 1'b0, 18'h0,    1'b0, 1'b0, 32'hBFC0_0300}, // R6
        '{4'd6,  3'd5, 1'b1, 1'b0, 18'h0,    1'b0, 1'b0, 32'hBFC0_0400}, // R6
        '{4'd7,  3'd4, 1'b0, 1'b0, 18'h0,    1'b0, 1'b0, 32'h8000_0180}, // R7
        '{4'd7,  3'd2, 1'b0, 1'b0, 18'h0,    1'b0, 1'b0, 32'h8000_0000}, // R7
        '{4'd8,  3'd3, 1'b0, 1'b0, 18'h0,    1'b0, 1'b0, 32'hA000_0100}, // R8
        '{4'd7,  3'd5, 1'b0, 1'b0, 18'h0,    1'b0, 1'b0, 32'h8000_0200}, // R7
        '{4'd9,  3'd6, 1'b0, 1'b0, 18'h0,    1'b0, 1'b0, 32'hBFC0_0480}, // R9
        '{4'd10, 3'd6, 1'b0, 1'b0, 18'h0,    1'b1, 1'b0, 32'h9000_1000}, // R10
        '{4'd10, 3'd6, 1'b0, 1'b0, 18'h0,    1'b1, 1'b1, 32'hFF20_0200}, // R10
        '{4'd10, 3'd6, 1'b0, 1'b0, 18'h0,    1'b0, 1'b1, 32'hFF20_0200}, // R10
        '{4'd4,  3'd0, 1'b0, 1'b1, 18'h01234, 1'b0, 1'b0, 32'h8123_4000}, // R4
        '{4'd8,  3'd3, 1'b1, 1'b1, 18'h01234, 1'b0, 1'b0, 32'hA123_4300}, // R8
        '{4'd4,  3'd6, 1'b0, 1'b1, 18'h01234, 1'b0, 1'b0, 32'h8123_4480}, // R4
        '{4'd7,  3'd4, 1'b0, 1'b1, 18'h01234, 1'b0, 1'b0, 32'h8000_0180}  // R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [31:0] d, input logic en);
        @(negedge clk);
        wr_en   = en;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        #1;
    endtask

    task automatic set_vec(input logic [2:0] k, input logic bev);
        @(negedge clk);
        exc_kind      = k;
        boot_vec_mode = bev;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1", rd_data, 32'h8000_02A5);

        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            exc_kind       = TBL[i].kind;
            boot_vec_mode  = TBL[i].bev;
            rom_reloc_en   = TBL[i].reloc;
            rom_reloc_page = TBL[i].page;
            dbg_vec_en     = TBL[i].den;
            probe_present  = TBL[i].probe;
            #1;
            check($sformatf("R%0d row %0d", TBL[i].req, i), vec_addr, TBL[i].exp);
        end
        @(negedge clk);
        rom_reloc_en = 1'b0;
        dbg_vec_en = 1'b0;
        probe_present = 1'b0;

        // R11: write while normal mode; vector uses new base next cycle
        set_vec(3'd4, 1'b0);
        check("R11 before write", vec_addr, 32'h8000_0180);
        write_reg(32'h1234_5FFF, 1'b1);
        check("R2 write value", rd_data, 32'h9234_52A5);
        check("R11 general after write", vec_addr, 32'h9234_5180);
        set_vec(3'd3, 1'b0);
        check("R8 cache err on written base", vec_addr, 32'hB234_5100);
        set_vec(3'd4, 1'b1);
        check("R6 boot mode ignores written base", vec_addr, 32'hBFC0_0380);

        // R2: no strobe, no change
        write_reg(32'h0000_0000, 1'b0);
        check("R2 hold without strobe", rd_data, 32'h9234_52A5);

        // R2 fixed bits / R3 cpu number ignores write data
        write_reg(32'h7FFF_FFFF, 1'b1);
        check("R2 fixed fields", rd_data, 32'hBFFF_F2A5);
        write_reg(32'hFFFF_F000, 1'b1);
        check("R3 cpu bits ignore write", rd_data, 32'hBFFF_F2A5);

        @(negedge clk);
        cpu_num_strap = 10'h155;
        #1;
        check("R3 strap follow", rd_data, 32'hBFFF_F155);

        write_reg(32'h0000_0000, 1'b1);
        check("R2 write zero", rd_data, 32'h8000_0155);
        set_vec(3'd2, 1'b0);
        check("R7 tlb after clear", vec_addr, 32'h8000_0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule